// File: doc/BRIEF.md
# Bus Breakpoint Comparator Unit

This block is a set of hardware breakpoint comparators that sit beside a processor's buses. There are six buses: three read buses, two write buses and one instruction-fetch bus. Each comparator slot is programmed through a small register write port. A slot selects one bus and decides whether to look at the address or the data on it. It then tests the chosen value against an exact value, an inclusive window, or the region outside a window. A slot can instead test a store: it fires when a given address is written with a value other than an expected one. The comparison logic only observes the buses, so the processor never stalls and never gives up cycles.

Each slot produces a registered match event. Any event raises a halt request toward the debug logic, and the request stays high until the debugger acknowledges it. A sticky status vector records which slots have fired since the last acknowledge. Typical uses are:

- catching a jump into unused program memory;
- catching an array index that runs past a limit;
- guarding a window below the stack;
- trapping a wrong value stored to a variable.

Top module: `bus_bkpt_unit`

## Requirements
- R1: While `rst_n` is low, `match_evt`, `halt_req` and `hit_status` are all zero, and every slot's configuration is cleared, which leaves the slot disabled.
- R2: A slot whose control bit 0 (enable) is 0 never produces a match event, whatever appears on the buses.
- R3: Control bits [3:1] select the bus: 0–2 are read buses, 3–4 are write buses, 5 is the fetch bus. A slot reacts only to the bus it selects, and codes 6 and 7 never match.
- R4: A bus cycle is compared only when that bus's bit in `bus_valid` is 1. Bus b occupies bits [b*AW +: AW] of `bus_addr` and [b*DW +: DW] of `bus_data`.
- R5: In mode 0 (control bits [6:5] = 0), a slot matches when the compared value equals the low register (field 1). Control bit 4 chooses the compared value: 1 selects data, 0 selects address.
- R6: In mode 1, a slot matches when low ≤ value ≤ high. The high bound is field 2, and both bounds are inclusive.
- R7: In mode 2, a slot matches when value < low or value > high. In both mode 1 and mode 2, a pair with low > high never matches.
- R8: In mode 3, a slot matches when the bus address equals the low register and the bus data differs from the expected register (field 3). Control bit 4 is ignored in this mode.
- R9: A match event appears on `match_evt` exactly one clock after the bus cycle that caused it, and lasts one cycle per matching cycle. `halt_req` rises in that same cycle.
- R10: `halt_req` stays high until a cycle with `dbg_ack` high. A new match in the acknowledge cycle keeps it high.
- R11: `hit_status` accumulates the match events. `dbg_ack` clears it, but bits for matches arriving in the acknowledge cycle are kept.
- R12: A configuration write (`cfg_we`, with `cfg_slot`, field `cfg_sel`, value `cfg_wdata`) takes effect for bus cycles from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 6 | Per-bus cycle strobe |
| bus_addr | input | 6*AW | Packed bus addresses |
| bus_data | input | 6*DW | Packed bus data values |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLW | Slot written |
| cfg_sel | input | 2 | Field: 0 control, 1 low, 2 high, 3 expected |
| cfg_wdata | input | CW | Field value |
| dbg_ack | input | 1 | Debugger acknowledge, clears halt and status |
| match_evt | output | NUM_SLOTS | Registered per-slot match events |
| halt_req | output | 1 | Sticky halt request |
| hit_status | output | NUM_SLOTS | Sticky record of fired slots |

## Verification
Addresses and data are driven on a chosen bus, with matching values also placed on other buses and with the strobe dropped. This separates a correct bus choice from one that ignores the selector or the strobe. Values are placed one below, at, and one above each bound, which exposes an off-by-one error or a swapped inclusive/exclusive test. Reversed bound pairs show that the order check is applied. In store-checking mode, the equal value, the differing value, and a near-miss address tell the two qualifiers apart. Acknowledges are given both alone and in the same cycle as a fresh match, which separates set-wins behaviour from clear-wins behaviour.

// File: rtl/bus_bkpt_unit.sv
module bus_bkpt_unit #(
  parameter int NUM_SLOTS = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int NBUS = 6,
  localparam int SLW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBUS-1:0]      bus_valid,
  input  logic [NBUS*AW-1:0]   bus_addr,
  input  logic [NBUS*DW-1:0]   bus_data,
  input  logic                 cfg_we,
  input  logic [SLW-1:0]       cfg_slot,
  input  logic [1:0]           cfg_sel,
  input  logic [CW-1:0]        cfg_wdata,
  input  logic                 dbg_ack,
  output logic [NUM_SLOTS-1:0] match_evt,
  output logic                 halt_req,
  output logic [NUM_SLOTS-1:0] hit_status
);

  localparam logic [1:0] M_EXACT = 2'd0;
  localparam logic [1:0] M_INSIDE = 2'd1;
  localparam logic [1:0] M_OUTSIDE = 2'd2;
  localparam logic [1:0] M_STORE = 2'd3;

  logic [NUM_SLOTS-1:0] ctl_en, ctl_dat, match_nxt;
  logic [2:0]    ctl_bus  [NUM_SLOTS];
  logic [1:0]    ctl_mode [NUM_SLOTS];
  logic [CW-1:0] lo_q     [NUM_SLOTS];
  logic [CW-1:0] hi_q     [NUM_SLOTS];
  logic [CW-1:0] exp_q    [NUM_SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= '0;
      ctl_dat <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        ctl_bus[s]  <= '0;
        ctl_mode[s] <= '0;
        lo_q[s]     <= '0;
        hi_q[s]     <= '0;
        exp_q[s]    <= '0;
      end
    end else if (cfg_we) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cfg_slot == SLW'(s)) begin
          case (cfg_sel)
            2'd0: begin
              ctl_en[s]   <= cfg_wdata[0];
              ctl_bus[s]  <= cfg_wdata[3:1];
              ctl_dat[s]  <= cfg_wdata[4];
              ctl_mode[s] <= cfg_wdata[6:5];
            end
            2'd1: lo_q[s]  <= cfg_wdata;
            2'd2: hi_q[s]  <= cfg_wdata;
            default: exp_q[s] <= cfg_wdata;
          endcase
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic          v, hit, ordered;
    logic [CW-1:0] a, d, val;

    always_comb begin
      v = 1'b0;
      a = '0;
      d = '0;
      if (ctl_bus[s] < 3'(NBUS)) begin
        v = bus_valid[ctl_bus[s]];
        a[AW-1:0] = bus_addr[ctl_bus[s]*AW +: AW];
        d[DW-1:0] = bus_data[ctl_bus[s]*DW +: DW];
      end
    end

    assign val = ctl_dat[s] ? d : a;
    assign ordered = (lo_q[s] <= hi_q[s]);

    always_comb begin
      case (ctl_mode[s])
        M_EXACT:   hit = (val == lo_q[s]);
        M_INSIDE:  hit = ordered && (val >= lo_q[s]) && (val <= hi_q[s]);
        M_OUTSIDE: hit = ordered && ((val < lo_q[s]) || (val > hi_q[s]));
        M_STORE:   hit = (a == lo_q[s]) && (d != exp_q[s]);
        default:   hit = 1'b0;
      endcase
    end

    assign match_nxt[s] = ctl_en[s] & v & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_evt  <= '0;
      halt_req   <= 1'b0;
      hit_status <= '0;
    end else begin
      match_evt  <= match_nxt;
      halt_req   <= (|match_nxt) | (halt_req & ~dbg_ack);
      hit_status <= match_nxt | (hit_status & ~{NUM_SLOTS{dbg_ack}});
    end
  end

endmodule

module bus_bkpt_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dbg_ack,
  input logic [NUM_SLOTS-1:0] match_evt,
  input logic                 halt_req,
  input logic [NUM_SLOTS-1:0] hit_status,
  input logic [NUM_SLOTS-1:0] ctl_en
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (match_evt == '0 && !halt_req && hit_status == '0));

  // R2
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt & ~$past(ctl_en)) == '0);

  // R9
  event_raises_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt != '0) |-> halt_req);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !dbg_ack) |=> halt_req);

  // R10
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> $past(dbg_ack));

  // R11
  status_covers_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt & ~hit_status) == '0);

endmodule

bind bus_bkpt_unit bus_bkpt_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .dbg_ack(dbg_ack), .match_evt(match_evt),
  .halt_req(halt_req), .hit_status(hit_status), .ctl_en(ctl_en)
);

// File: tb/bus_bkpt_unit_tb_top.sv
`timescale 1ns/1ps
module bus_bkpt_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  bv = '0;
  logic [15:0] ba [6];
  logic [15:0] bd [6];
  logic [95:0] bus_addr, bus_data;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_slot = '0, cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic dbg_ack = 1'b0;
  logic [3:0] match_evt, hit_status;
  logic halt_req;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  always_comb
    for (int b = 0; b < 6; b++) begin
      bus_addr[b*16 +: 16] = ba[b];
      bus_data[b*16 +: 16] = bd[b];
    end

  bus_bkpt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_addr(bus_addr),
    .bus_data(bus_data), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dbg_ack(dbg_ack),
    .match_evt(match_evt), .halt_req(halt_req), .hit_status(hit_status)
  );

  bit [6:0]  m_ctl [4];
  bit [15:0] m_lo [4], m_hi [4], m_ex [4];
  bit [3:0]  e_evt, e_stat;
  bit        e_halt;

  function automatic bit model_hit(int s);
    int b, a, d, v, lo, hi;
    b = int'(m_ctl[s][3:1]);
    if (!m_ctl[s][0] || b > 5) return 0;
    if (!bv[b]) return 0;
    a = int'(ba[b]); d = int'(bd[b]);
    lo = int'(m_lo[s]); hi = int'(m_hi[s]);
    v = m_ctl[s][4] ? d : a;
    case (m_ctl[s][6:5])
      2'd0: return v == lo;
      2'd1: return lo <= hi && v >= lo && v <= hi;
      2'd2: return lo <= hi && (v < lo || v > hi);
      default: return a == lo && d != int'(m_ex[s]);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit [3:0] hits;
    if (!rst_n) begin
      e_evt = 0; e_stat = 0; e_halt = 0;
      for (int s = 0; s < 4; s++) begin
        m_ctl[s] = 0; m_lo[s] = 0; m_hi[s] = 0; m_ex[s] = 0;
      end
    end else begin
      for (int s = 0; s < 4; s++) hits[s] = model_hit(s);
      e_halt = (hits != 0) || (e_halt && !dbg_ack);
      e_stat = hits | (dbg_ack ? 4'b0 : e_stat);
      e_evt = hits;
      if (cfg_we)
        case (cfg_sel)
          2'd0: m_ctl[cfg_slot] = cfg_wdata[6:0];
          2'd1: m_lo[cfg_slot] = cfg_wdata;
          2'd2: m_hi[cfg_slot] = cfg_wdata;
          default: m_ex[cfg_slot] = cfg_wdata;
        endcase
    end
  end

  always @(negedge clk) begin
    checks++;
    if (match_evt !== e_evt || halt_req !== e_halt || hit_status !== e_stat) begin
      errors++;
      $display("FAIL %s: evt=%h halt=%b stat=%h expected evt=%h halt=%b stat=%h",
               tag, match_evt, halt_req, hit_status, e_evt, e_halt, e_stat);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int slot, int sel, int val);
    cfg_we = 1; cfg_slot = 2'(slot); cfg_sel = 2'(sel); cfg_wdata = 16'(val);
    cyc();
    cfg_we = 0;
  endtask

  function automatic int mk(int en, int bus, int dat, int mode);
    return en | (bus << 1) | (dat << 4) | (mode << 5);
  endfunction

  task automatic drv(int b, int a, int d, bit v = 1);
    ba[b] = 16'(a); bd[b] = 16'(d); bv[b] = v;
    cyc();
    bv = '0;
  endtask

  task automatic ack();
    dbg_ack = 1; cyc(); dbg_ack = 0;
  endtask

  task automatic chk_halt(string t, bit exp);
    checks++;
    if (halt_req !== exp) begin
      errors++;
      $display("FAIL %s: halt_req=%b expected %b", t, halt_req, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < 6; b++) begin ba[b] = '0; bd[b] = '0; end
    tag = "R1"; cyc(3);
    chk_halt("R1", 0);
    rst_n = 1; cyc();

    tag = "R12"; cfg(0, 0, mk(1, 0, 0, 0)); cfg(0, 1, 'h100);
    tag = "R5"; drv(0, 'h101, 0); chk_halt("R5", 0);
    drv(0, 'h100, 0); chk_halt("R9", 1);
    cyc(); chk_halt("R10", 1);
    ack(); chk_halt("R10", 0);
    cfg(1, 0, mk(1, 5, 1, 0)); cfg(1, 1, 'hBEEF);
    drv(5, 'hBEEF, 0); chk_halt("R5", 0);
    drv(5, 0, 'hBEEF); chk_halt("R5", 1); ack();

    tag = "R2"; cfg(0, 0, mk(0, 0, 0, 0)); cfg(1, 0, mk(0, 5, 1, 0));
    drv(0, 'h100, 0); drv(5, 0, 'hBEEF); chk_halt("R2", 0);

    tag = "R3"; cfg(0, 0, mk(1, 3, 0, 0));
    drv(0, 'h100, 0); chk_halt("R3", 0);
    drv(3, 'h100, 0); chk_halt("R3", 1); ack();
    cfg(0, 0, mk(1, 6, 0, 0));
    for (int b = 0; b < 6; b++) begin ba[b] = 'h100; bv[b] = 1; end
    cyc(); bv = '0; chk_halt("R3", 0);

    tag = "R4"; cfg(0, 0, mk(1, 3, 0, 0));
    drv(3, 'h100, 0, 0); chk_halt("R4", 0); cfg(0, 0, 0);

    tag = "R6"; cfg(2, 1, 10); cfg(2, 2, 20); cfg(2, 0, mk(1, 1, 0, 1));
    drv(1, 9, 0); chk_halt("R6", 0);
    drv(1, 10, 0); chk_halt("R6", 1); ack();
    drv(1, 20, 0); chk_halt("R6", 1); ack();
    drv(1, 21, 0); chk_halt("R6", 0);

    tag = "R7"; cfg(2, 1, 0); cfg(2, 2, 100); cfg(2, 0, mk(1, 1, 0, 2));
    drv(1, 100, 0); chk_halt("R7", 0);
    drv(1, 101, 0); chk_halt("R7", 1); ack();
    cfg(2, 1, 50); cfg(2, 2, 40);
    drv(1, 30, 0); drv(1, 45, 0); drv(1, 60, 0); chk_halt("R7", 0);
    cfg(2, 0, mk(1, 1, 0, 1));
    drv(1, 45, 0); drv(1, 50, 0); chk_halt("R7", 0); cfg(2, 0, 0);

    tag = "R8"; cfg(3, 1, 'h40); cfg(3, 3, 'h55); cfg(3, 0, mk(1, 4, 1, 3));
    drv(4, 'h40, 'h55); chk_halt("R8", 0);
    drv(4, 'h41, 'h56); chk_halt("R8", 0);
    drv(4, 'h40, 'h56); chk_halt("R8", 1); ack();

    tag = "R11"; cfg(0, 0, mk(1, 0, 0, 0));
    ba[0] = 'h100; bv[0] = 1; ba[4] = 'h40; bd[4] = 'h99; bv[4] = 1;
    cyc(); bv = '0;
    checks++;
    if (hit_status !== 4'b1001) begin
      errors++; $display("FAIL R11: hit_status=%h expected 9", hit_status);
    end
    tag = "R10"; dbg_ack = 1; ba[0] = 'h100; bv[0] = 1;
    cyc(); dbg_ack = 0; bv = '0;
    chk_halt("R10", 1);
    checks++;
    if (hit_status !== 4'b0001) begin
      errors++; $display("FAIL R11: hit_status=%h expected 1", hit_status);
    end
    cyc(2); ack(); chk_halt("R10", 0);
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule